// File: doc/BRIEF.md
# Page Write Buffer and Program-Cycle Controller

This block sits behind a two-wire bus protocol engine in a serial non-volatile memory. Within one write command it gathers data bytes into a page-sized holding buffer. When the command ends it hands them to the memory array in a self-timed program window. The protocol engine gives it the word address at the start of the command, then one strobe for each data byte it accepts. It also reports the STOP that closes the command and any abort, meaning a repeated START seen before STOP. A write-protect input blocks all programming.

The address splits into a page row, the upper `ADDR_W-OFF_W` bits, and a byte offset, the low `OFF_W` bits. Only the offset advances after each byte, and it wraps inside the page, so an overlong burst overwrites its own earlier bytes. When a command with data closes, `busy_o` rises for `PROG_CYCLES` clocks. The protocol engine uses that flag to withhold acknowledges. At the start of that window the buffered bytes are written to the array, one per clock, in ascending offset order. Commands that carry no data, and commands closed while write-protect is high, leave the array untouched and never raise busy.

Top module: `page_prog_ctrl`

## Requirements
- R1: After reset `busy_o` and `mem_we_o` are low and no byte is pending.
- R2: `cmd_start_i` in standby or while collecting latches the row from `addr_i[ADDR_W-1:OFF_W]` and the offset from `addr_i[OFF_W-1:0]`, and discards any bytes already collected.
- R3: Each `byte_vld_i` while collecting stores `byte_i` at the current offset, then increments only the offset, modulo 2^OFF_W. The row never changes within a command.
- R4: When more than 2^OFF_W bytes arrive, the offset wraps, and a later byte replaces the earlier byte at the same offset.
- R5: During the program window, clock n (n = 0 being the clock after the STOP edge) writes offset n if, and only if, a byte was received there. Address `{row, n}` and the last byte stored at that offset are driven with it. Offsets never received are not written, and each position is written once.
- R6: A STOP with at least one received byte and `wp_i` low holds `busy_o` high for exactly PROG_CYCLES clocks, starting the clock after the STOP edge. The block then returns to standby.
- R7: While `busy_o` is high, `cmd_start_i`, `byte_vld_i`, `stop_i` and `abort_i` have no effect.
- R8: A STOP while `wp_i` is high discards the collected bytes. `busy_o` stays low and nothing is written.
- R9: A STOP with zero received bytes, such as the dummy write before a random read, leaves `busy_o` low and writes nothing.
- R10: `abort_i` while collecting discards all collected bytes and returns to standby. It wins over `stop_i`, `cmd_start_i` and `byte_vld_i` in the same clock. Among the rest, `cmd_start_i` beats `stop_i`, which beats `byte_vld_i`.
- R11: `mem_we_o` is never high while `wp_i` is high, including when `wp_i` rises inside the program window.
- R12: `byte_vld_i` and `stop_i` in standby, with no command open, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_start_i | input | 1 | Write command opens; load address |
| addr_i | input | ADDR_W | Word address of the first byte |
| byte_vld_i | input | 1 | Data byte accepted by the protocol engine |
| byte_i | input | DATA_W | Data byte |
| stop_i | input | 1 | STOP closes the command |
| abort_i | input | 1 | START seen before STOP |
| wp_i | input | 1 | Write protect, active high |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_data_o | output | DATA_W | Array write data |
| busy_o | output | 1 | Program cycle in progress |

## Verification
A wrong offset or valid mask in the buffer shows up only inside the program window after the next STOP. It appears as a write strobe in the wrong slot, a missing strobe, or a wrong data byte. So every scenario closes its command and runs through the full window. A corrupted row register or state register shows within one clock of the STOP, as a bad row on `mem_addr_o` or a busy flag that rises or falls when it should not. The reference is compared on every clock so that a single misplaced slot is caught.

// File: rtl/pp_pkg.sv
package pp_pkg;
  typedef enum logic [1:0] {
    PP_IDLE = 2'd0,
    PP_FILL = 2'd1,
    PP_PROG = 2'd2
  } pp_state_e;
endpackage

// File: rtl/pp_page_buf.sv
module pp_page_buf #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [OFF_W-1:0]  wr_off_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [OFF_W-1:0]  rd_off_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_hit_o,
  output logic              any_o
);
  localparam int NB = 1 << OFF_W;

  logic [NB-1:0]     mask_q;
  logic [DATA_W-1:0] data_q [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      for (int i = 0; i < NB; i++) data_q[i] <= '0;
    end else if (clr_i) begin
      mask_q <= '0;
    end else if (wr_i) begin
      for (int i = 0; i < NB; i++) begin
        if (wr_off_i == OFF_W'(i)) begin
          mask_q[i] <= 1'b1;
          data_q[i] <= wr_data_i;
        end
      end
    end
  end

  assign rd_data_o = data_q[rd_off_i];
  assign rd_hit_o  = mask_q[rd_off_i];
  assign any_o     = |mask_q;
endmodule

// File: rtl/pp_addr_track.sv
module pp_addr_track #(
  parameter int ADDR_W = 13,
  parameter int OFF_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    ld_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    inc_i,
  output logic [ADDR_W-OFF_W-1:0] row_o,
  output logic [OFF_W-1:0]        off_o
);
  localparam int ROW_W = ADDR_W - OFF_W;

  logic [ROW_W-1:0] row_q;
  logic [OFF_W-1:0] off_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q <= '0;
      off_q <= '0;
    end else if (ld_i) begin
      row_q <= addr_i[ADDR_W-1:OFF_W];
      off_q <= addr_i[OFF_W-1:0];
    end else if (inc_i) begin
      off_q <= off_q + 1'b1; // wraps inside the page
    end
  end

  assign row_o = row_q;
  assign off_o = off_q;
endmodule

// File: rtl/pp_prog_timer.sv
module pp_prog_timer #(
  parameter int PROG_CYCLES = 250000,
  parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (launch_i) cnt_q <= '0;
    else if (run_i)    cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign done_o = (cnt_q == CNT_W'(PROG_CYCLES - 1));
endmodule

// File: rtl/pp_seq.sv
module pp_seq
  import pp_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      cmd_start_i,
  input  logic      byte_vld_i,
  input  logic      stop_i,
  input  logic      abort_i,
  input  logic      wp_i,
  input  logic      any_i,
  input  logic      done_i,
  output pp_state_e state_o,
  output logic      ld_o,
  output logic      clr_o,
  output logic      wr_o,
  output logic      launch_o
);
  pp_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    ld_o     = 1'b0;
    clr_o    = 1'b0;
    wr_o     = 1'b0;
    launch_o = 1'b0;
    unique case (state_q)
      PP_IDLE: begin
        if (cmd_start_i) begin
          state_d = PP_FILL;
          ld_o    = 1'b1;
          clr_o   = 1'b1;
        end
      end
      PP_FILL: begin
        if (abort_i) begin
          state_d = PP_IDLE;
          clr_o   = 1'b1;
        end else if (cmd_start_i) begin
          ld_o  = 1'b1;
          clr_o = 1'b1;
        end else if (stop_i) begin
          if (any_i && !wp_i) begin
            state_d  = PP_PROG;
            launch_o = 1'b1;
          end else begin
            state_d = PP_IDLE;
            clr_o   = 1'b1;
          end
        end else if (byte_vld_i) begin
          wr_o = 1'b1;
        end
      end
      PP_PROG: begin
        if (done_i) begin
          state_d = PP_IDLE;
          clr_o   = 1'b1;
        end
      end
      default: state_d = PP_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PP_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl
  import pp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int OFF_W       = 5,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              stop_i,
  input  logic              abort_i,
  input  logic              wp_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  output logic              busy_o
);
  localparam int ROW_W      = ADDR_W - OFF_W;
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int CNT_W      = $clog2(PROG_CYCLES + 1);

  pp_state_e         state;
  logic              ld, clr, wr, launch, any, done, hit, in_slot;
  logic [ROW_W-1:0]  row;
  logic [OFF_W-1:0]  wr_off, rd_off;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rd_data;

  pp_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_start_i (cmd_start_i),
    .byte_vld_i  (byte_vld_i),
    .stop_i      (stop_i),
    .abort_i     (abort_i),
    .wp_i        (wp_i),
    .any_i       (any),
    .done_i      (done),
    .state_o     (state),
    .ld_o        (ld),
    .clr_o       (clr),
    .wr_o        (wr),
    .launch_o    (launch)
  );

  pp_addr_track #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld),
    .addr_i (addr_i),
    .inc_i  (wr),
    .row_o  (row),
    .off_o  (wr_off)
  );

  pp_page_buf #(.DATA_W(DATA_W), .OFF_W(OFF_W)) u_buf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .wr_i      (wr),
    .wr_off_i  (wr_off),
    .wr_data_i (byte_i),
    .rd_off_i  (rd_off),
    .rd_data_o (rd_data),
    .rd_hit_o  (hit),
    .any_o     (any)
  );

  pp_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .launch_i (launch),
    .run_i    (state == PP_PROG),
    .cnt_o    (cnt),
    .done_o   (done)
  );

  // Commit slots occupy the first PAGE_BYTES clocks of the busy window.
  assign rd_off     = cnt[OFF_W-1:0];
  assign in_slot    = (cnt < CNT_W'(PAGE_BYTES));
  assign busy_o     = (state == PP_PROG);
  assign mem_we_o   = busy_o && in_slot && hit && !wp_i;
  assign mem_addr_o = {row, rd_off};
  assign mem_data_o = rd_data;
endmodule

// File: rtl/page_prog_ctrl_chk.sv
module page_prog_ctrl_chk #(
  parameter int ADDR_W      = 13,
  parameter int OFF_W       = 5,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 250000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stop_i,
  input logic              wp_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_data_o,
  input logic              busy_o
);
  localparam int LEN_W = $clog2(PROG_CYCLES + 2);

  logic [LEN_W-1:0] busy_len_q;
  logic [OFF_W-1:0] last_off_q;
  logic             seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_len_q <= '0;
      last_off_q <= '0;
      seen_q     <= 1'b0;
    end else begin
      busy_len_q <= busy_o ? busy_len_q + 1'b1 : '0;
      if (!busy_o) seen_q <= 1'b0;
      else if (mem_we_o) begin
        seen_q     <= 1'b1;
        last_off_q <= mem_addr_o[OFF_W-1:0];
      end
    end
  end

  assert_we_in_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> busy_o);

  assert_offset_ascends_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && seen_q) |-> (mem_addr_o[OFF_W-1:0] > last_off_q));

  assert_row_fixed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |->
      (mem_addr_o[ADDR_W-1:OFF_W] == $past(mem_addr_o[ADDR_W-1:OFF_W])));

  assert_busy_from_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(stop_i) && !$past(wp_i));

  assert_busy_len_max_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len_q <= LEN_W'(PROG_CYCLES));

  assert_busy_len_exact_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (busy_len_q == LEN_W'(PROG_CYCLES)));

  assert_no_we_under_wp_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !mem_we_o);

  assert_data_known_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> !$isunknown(mem_data_o));
endmodule

bind page_prog_ctrl page_prog_ctrl_chk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .stop_i     (stop_i),
  .wp_i       (wp_i),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .busy_o     (busy_o)
);

// File: tb/tb_page_prog_ctrl.sv
module tb_page_prog_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 13;
  localparam int OFF_W  = 5;
  localparam int DATA_W = 8;
  localparam int PROG   = 40;
  localparam int NB     = 1 << OFF_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_start = 1'b0, byte_vld = 1'b0, stop = 1'b0, abort = 1'b0, wp = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] bdat = '0;
  logic              mem_we, busy;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_data;

  int vectors = 0;
  int errors  = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  page_prog_ctrl #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .PROG_CYCLES(PROG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_start_i(cmd_start), .addr_i(addr),
    .byte_vld_i(byte_vld), .byte_i(bdat), .stop_i(stop), .abort_i(abort), .wp_i(wp),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .busy_o(busy)
  );

  // Behavioural reference: 0 standby, 1 collecting, 2 programming
  int m_mode = 0;
  int m_row = 0, m_off = 0, m_cnt = 0;
  int m_data [int];   // offset -> byte, present only if received

  task automatic check(input string what, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic check_v(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_data.delete();
    end else begin
      case (m_mode)
        0: if (cmd_start) begin
             m_mode = 1; m_row = int'(addr) / NB; m_off = int'(addr) % NB; m_data.delete();
           end
        1: if (abort) begin
             m_mode = 0; m_data.delete();
           end else if (cmd_start) begin
             m_row = int'(addr) / NB; m_off = int'(addr) % NB; m_data.delete();
           end else if (stop) begin
             if (m_data.num() > 0 && !wp) begin m_mode = 2; m_cnt = 0; end
             else begin m_mode = 0; m_data.delete(); end
           end else if (byte_vld) begin
             m_data[m_off] = int'(bdat);
             m_off = (m_off + 1) % NB;
           end
        default: if (m_cnt == PROG - 1) begin
                   m_mode = 0; m_data.delete();
                 end else m_cnt++;
      endcase
      #(CLK_PERIOD/4);
      begin
        logic exp_we;
        exp_we = (m_mode == 2) && (m_cnt < NB) && m_data.exists(m_cnt) && !wp;
        check("busy_o", busy, m_mode == 2);
        check("mem_we_o", mem_we, exp_we);
        if (exp_we) begin
          check_v("mem_addr_o", int'(mem_addr), m_row * NB + m_cnt);
          check_v("mem_data_o", int'(mem_data), m_data[m_cnt]);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
    cmd_start = 0; byte_vld = 0; stop = 0; abort = 0;
  endtask

  task automatic open_cmd(input int a);
    @(negedge clk); cmd_start = 1; addr = ADDR_W'(a);
    step();
  endtask

  task automatic send_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); byte_vld = 1; bdat = DATA_W'(base + i);
      step();
    end
  endtask

  task automatic close_cmd();
    @(negedge clk); stop = 1;
    step();
  endtask

  task automatic wait_idle();
    for (int i = 0; i < PROG + 8; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL R6 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2);
    // R1: reset state
    check("reset busy_o", busy, 1'b0);
    check("reset mem_we_o", mem_we, 1'b0);
    @(negedge clk); rst_n = 1;
    step(); step();

    cur_req = "R3"; // single byte, row 9 offset 3
    open_cmd(13'h0123); send_bytes(1, 8'h5a); close_cmd(); wait_idle();

    cur_req = "R5"; // partial page that wraps: 30,31,0,1,2
    open_cmd(13'h1ffe); send_bytes(5, 8'h10); close_cmd(); wait_idle();

    cur_req = "R4"; // 40 bytes overwrite offsets 0..7
    open_cmd(13'h0400); send_bytes(40, 8'h80); close_cmd(); wait_idle();

    cur_req = "R8"; // protected
    wp = 1; open_cmd(13'h0040); send_bytes(3, 8'h33); close_cmd(); wait_idle(); wp = 0;

    cur_req = "R9"; // dummy write closed by STOP, then by abort
    open_cmd(13'h0777); close_cmd(); wait_idle();
    open_cmd(13'h0777); @(negedge clk); abort = 1; step(); wait_idle();

    cur_req = "R10"; // abort after data, abort with stop same clock
    open_cmd(13'h0200); send_bytes(4, 8'h44); @(negedge clk); abort = 1; step(); close_cmd(); wait_idle();
    open_cmd(13'h0200); send_bytes(2, 8'h66);
    @(negedge clk); abort = 1; stop = 1; byte_vld = 1; step(); wait_idle();

    cur_req = "R2"; // restart while collecting drops earlier bytes
    open_cmd(13'h0300); send_bytes(3, 8'h70); open_cmd(13'h0a0c); send_bytes(2, 8'hc0);
    close_cmd(); wait_idle();

    cur_req = "R7"; // traffic during busy ignored
    open_cmd(13'h0100); send_bytes(2, 8'h21); close_cmd();
    open_cmd(13'h0f00); send_bytes(3, 8'h99);
    @(negedge clk); stop = 1; abort = 1; step();
    wait_idle();

    cur_req = "R12"; // bytes and stop in standby
    send_bytes(2, 8'hee); close_cmd(); wait_idle();

    cur_req = "R11"; // wp rises mid window
    open_cmd(13'h0500); send_bytes(32, 8'h00); close_cmd();
    for (int i = 0; i < 10; i++) step();
    wp = 1; for (int i = 0; i < 8; i++) step();
    wp = 0; wait_idle();

    cur_req = "R6"; // busy flag after window
    step();
    check("busy_o after window", busy, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule